// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block exposes a 256-entry, byte-wide configuration register file through a pair of I/O ports. Software writes an index to the even port and then reads or writes the selected entry through the odd port. Each entry has a fixed power-on value. A sparse protection map in the upper index range blocks writes to many entries. Two entries are pinned to a single legal value. Writing any other value to either of them is refused and produces a one-cycle warning pulse.

A global enable input decides whether the port pair answers at all. While the enable is low, no access changes state and reads are not claimed. Read data is registered and appears one cycle after the read strobe, together with a claim flag. In every other cycle the read bus idles at 0xFF.

Top module: `cfg_index_port`

## Requirements
- R1: A write strobe with `port_en` high and `addr_lsb` = 0 loads `wdata` into the index register. The index register resets to 0x00 and changes on no other access.
- R2: A read strobe with `port_en` high and `addr_lsb` = 1 returns the entry at the current index on `rdata` in the next cycle, with `claimed` = 1 in that same cycle.
- R3: A data-port write (`addr_lsb` = 1, `port_en` high) updates the entry at the current index for every index not listed in R4. Entries 0xE7 and 0xE8 follow R6 instead.
- R4: Data-port writes are ignored for these indices: 0x00 to 0xDF, 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, and 0xFD to 0xFF.
- R5: Reset gives entry 0xE0 the value 0x3C, 0xE2 the value 0x03, 0xE3 the value 0xFC, 0xE6 the value 0xDE, 0xE7 the value 0xFE and 0xE8 the value 0xBE. Every other entry resets to 0x00.
- R6: Entry 0xE7 only ever holds 0xFE and entry 0xE8 only ever holds 0xBE. A data-port write of any other value to either entry is refused, and `unsupported` is high for exactly the next cycle. Writing the pinned value raises no flag.
- R7: While `port_en` is low, accesses change neither the index nor any entry. Reads return 0xFF with `claimed` = 0, and `unsupported` stays low.
- R8: In any cycle that does not follow an enabled odd-port read, `rdata` is 0xFF and `claimed` is 0. This includes the cycle after a read of the index port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Global enable for the port pair |
| addr_lsb | input | 1 | Port select: 0 = index, 1 = data |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0xFF when idle |
| claimed | output | 1 | High in the cycle that carries valid read data |
| unsupported | output | 1 | One-cycle pulse after a refused write to a pinned entry |

## Verification
The hardest case to reach is a protected or pinned entry that silently keeps its old value. No output changes at the moment of the refused write, so the write cannot be seen as it happens. The stimulus therefore writes a distinct value to every one of the 256 indices. It then reads the whole file back and compares each entry with a bench model of the protection map and the reset defaults. The disabled case is handled the same way: the bench attempts index and data writes with the enable low, raises the enable again, and reads back both the index and the entry.

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] rdata;
        logic              claimed;
        logic              unsup;
    } port_state_t;

    // indices whose entries software may never change
    function automatic logic is_locked(input logic [7:0] i);
        logic r;
        r = 1'b0;
        if (i <= 8'hDF) r = 1'b1;
        if (i == 8'hE4 || i == 8'hE5 || i == 8'hF3 || i == 8'hF5 || i == 8'hF7) r = 1'b1;
        if (i >= 8'hE9 && i <= 8'hED) r = 1'b1;
        if (i >= 8'hF9 && i <= 8'hFB) r = 1'b1;
        if (i >= 8'hFD) r = 1'b1;
        return r;
    endfunction

    function automatic logic is_pinned(input logic [7:0] i);
        return (i == 8'hE7) || (i == 8'hE8);
    endfunction

    function automatic logic [7:0] pinned_value(input logic [7:0] i);
        return (i == 8'hE7) ? 8'hFE : 8'hBE;
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] i);
        logic [7:0] v;
        case (i)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cfg_wr_policy.sv
`timescale 1ns/1ps
module cfg_wr_policy
    import cfg_port_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          req,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] val,
    output logic          commit,
    output logic          refuse_pin
);
    logic locked;
    logic pinned;
    logic pin_ok;

    always_comb begin
        locked     = is_locked(8'(idx));
        pinned     = is_pinned(8'(idx));
        pin_ok     = (8'(val) == pinned_value(8'(idx)));
        commit     = req && !locked && (!pinned || pin_ok);
        refuse_pin = req && pinned && !pin_ok;
    end
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
    import cfg_port_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wval,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rval
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(reset_value(8'(i)));
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rval = mem_q[raddr];
endmodule

// File: rtl/cfg_index_port.sv
`timescale 1ns/1ps
module cfg_index_port
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              addr_lsb,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              claimed,
    output logic              unsupported
);
    port_state_t s_d, s_q;

    logic              data_wr;
    logic              data_rd;
    logic              idx_wr;
    logic              commit;
    logic              refuse_pin;
    logic [DATA_W-1:0] entry_val;

    assign data_wr = port_en && wr_stb && addr_lsb;
    assign data_rd = port_en && rd_stb && addr_lsb;
    assign idx_wr  = port_en && wr_stb && !addr_lsb;

    cfg_wr_policy #(.DW(DATA_W), .IW(IDX_W)) u_policy (
        .req        (data_wr),
        .idx        (s_q.idx),
        .val        (wdata),
        .commit     (commit),
        .refuse_pin (refuse_pin)
    );

    cfg_reg_file #(.DW(DATA_W), .IW(IDX_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (s_q.idx),
        .wval  (wdata),
        .raddr (s_q.idx),
        .rval  (entry_val)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rdata   = '1;
        s_d.claimed = 1'b0;
        s_d.unsup   = refuse_pin;
        if (idx_wr) s_d.idx = IDX_W'(wdata);
        if (data_rd) begin
            s_d.rdata   = entry_val;
            s_d.claimed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.idx     <= '0;
            s_q.rdata   <= '1;
            s_q.claimed <= 1'b0;
            s_q.unsup   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata       = s_q.rdata;
    assign claimed     = s_q.claimed;
    assign unsupported = s_q.unsup;

    // R1: index only moves on an enabled even-port write
    a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && wr_stb && !addr_lsb) |=> $stable(s_q.idx));
    // R2: an enabled data-port read is claimed next cycle
    a_r2_claim_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rd_stb && addr_lsb) |=> claimed);
    // R7: nothing is claimed or flagged while disabled
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!claimed && !unsupported && rdata == 8'hFF));
    // R8: idle read bus
    a_r8_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !claimed |-> rdata == 8'hFF);
    // R6: refusal pulse needs a preceding data write and lasts one cycle
    a_r6_unsup_single: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> ($past(port_en && wr_stb && addr_lsb) && !$past(unsupported)));
    // R6: pinned entries keep their single legal value
    a_r6_pin_e7_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        u_rf.mem_q[8'hE7] == 8'hFE);
    a_r6_pin_e8_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        u_rf.mem_q[8'hE8] == 8'hBE);
    // R4: a protected entry never changes after reset
    a_r4_top_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(u_rf.mem_q[8'hFF]));
endmodule

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/1ps
module cfg_index_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       addr_lsb = 1'b0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       claimed;
    logic       unsupported;

    int n_cmp = 0;
    int n_bad = 0;
    int pcnt  = 0;
    bit done  = 1'b0;

    logic [7:0] model [256];
    logic [7:0] m_idx;

    int         q_stamp [$];
    logic [9:0] q_val   [$];
    string      q_tag   [$];

    always #10 clk = ~clk;

    cfg_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .addr_lsb(addr_lsb),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata),
        .rdata(rdata), .claimed(claimed), .unsupported(unsupported)
    );

    function automatic logic locked_m(input logic [7:0] i);
        return (i <= 8'hDF) || i == 8'hE4 || i == 8'hE5 || (i >= 8'hE9 && i <= 8'hED) ||
               i == 8'hF3 || i == 8'hF5 || i == 8'hF7 || (i >= 8'hF9 && i <= 8'hFB) ||
               (i >= 8'hFD);
    endfunction

    function automatic logic [7:0] dflt_m(input logic [7:0] i);
        case (i)
            8'hE0: return 8'h3C;
            8'hE2: return 8'h03;
            8'hE3: return 8'hFC;
            8'hE6: return 8'hDE;
            8'hE7: return 8'hFE;
            8'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) model[i] = dflt_m(8'(i));
        m_idx = 8'h00;
    endtask

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual rdata=%h claimed=%b unsup=%b expected rdata=%h claimed=%b unsup=%b",
                     tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
        end
    endtask

    // driver: one bus cycle, expected result queued for the following edge
    task automatic cyc(input logic en, input logic a, input logic wr, input logic rd,
                       input logic [7:0] d, input string tag);
        logic [7:0] er;
        logic       ec, eu;
        @(negedge clk);
        port_en = en; addr_lsb = a; wr_stb = wr; rd_stb = rd; wdata = d;
        ec = en && rd && a;
        er = ec ? model[m_idx] : 8'hFF;
        eu = 1'b0;
        if (en && wr && !a) m_idx = d;
        if (en && wr && a && !locked_m(m_idx)) begin
            if (m_idx == 8'hE7 || m_idx == 8'hE8) begin
                if (d != dflt_m(m_idx)) eu = 1'b1;
            end else begin
                model[m_idx] = d;
            end
        end
        q_stamp.push_back(pcnt + 1);
        q_val.push_back({er, ec, eu});
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        port_en = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        wait (q_stamp.size() == 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // monitor: compare queued expectations at their edge
    always @(posedge clk) begin
        pcnt++;
        #5;
        if (q_stamp.size() > 0 && q_stamp[0] == pcnt) begin
            check(q_tag[0], {rdata, claimed, unsupported}, q_val[0]);
            void'(q_stamp.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle outputs after reset
        check("R8 reset idle", {rdata, claimed, unsupported}, {8'hFF, 1'b0, 1'b0});
        // R1 R2 R5: read back all reset values (index starts at 0)
        cyc(1, 1, 0, 1, 8'h00, "R1 R5 index zero after reset");
        for (int i = 0; i < 256; i++) begin
            cyc(1, 0, 1, 0, 8'(i), "R1 index write");
            cyc(1, 1, 0, 1, 8'h00, "R2 R5 default readback");
        end
        // R8: even-port read is not claimed
        cyc(1, 0, 0, 1, 8'h00, "R8 index port read");
        // R3 R4 R6: write a distinct value to every index
        for (int i = 0; i < 256; i++) begin
            cyc(1, 0, 1, 0, 8'(i), "R1 index write");
            cyc(1, 1, 1, 0, 8'(i) ^ 8'h5A, "R3 R4 R6 data write");
        end
        for (int i = 0; i < 256; i++) begin
            cyc(1, 0, 1, 0, 8'(i), "R1 index write");
            cyc(1, 1, 0, 1, 8'h00, "R3 R4 readback");
        end
        // R6: pinned value accepted without flag, others flagged
        cyc(1, 0, 1, 0, 8'hE7, "R1 index write");
        cyc(1, 1, 1, 0, 8'hFE, "R6 pinned value no flag");
        cyc(1, 1, 1, 0, 8'h00, "R6 e7 refused");
        cyc(1, 1, 0, 1, 8'h00, "R6 e7 still fe");
        cyc(1, 0, 1, 0, 8'hE8, "R1 index write");
        cyc(1, 1, 1, 0, 8'hBF, "R6 e8 refused");
        cyc(1, 1, 1, 0, 8'hBE, "R6 e8 pinned no flag");
        cyc(1, 1, 0, 1, 8'h00, "R6 e8 still be");
        // R7: disabled accesses leave no trace
        cyc(1, 0, 1, 0, 8'hF0, "R1 index write");
        cyc(1, 1, 1, 0, 8'h77, "R3 writable f0");
        cyc(0, 0, 1, 0, 8'hF1, "R7 disabled index write");
        cyc(0, 1, 1, 0, 8'h99, "R7 disabled data write");
        cyc(0, 1, 0, 1, 8'h00, "R7 disabled read unclaimed");
        cyc(1, 1, 0, 1, 8'h00, "R7 index and entry unchanged");
        cyc(1, 0, 1, 0, 8'hE7, "R1 index write");
        cyc(0, 1, 1, 0, 8'h11, "R7 disabled pinned write no flag");
        cyc(1, 1, 0, 1, 8'h00, "R7 e7 unchanged");
        // R5: reset restores defaults
        do_reset();
        foreach (model[i]) if (i >= 8'hE0 && i <= 8'hF0) begin
            cyc(1, 0, 1, 0, 8'(i), "R1 index write");
            cyc(1, 1, 0, 1, 8'h00, "R5 default after second reset");
        end
        idle();
        idle();
        wait (q_stamp.size() == 0);
        idle();
        finish_run();
    end
endmodule